// File: doc/BRIEF.md
# Windowed Video Statistics Engine

This block watches a pixel stream of three colour channels and gathers one statistic per frame over a rectangular region of the picture. Position inside the picture comes from two counters. The column counter counts pixel clocks since the last horizontal reference edge. The row counter counts horizontal reference edges since the last vertical reference edge. A pixel contributes only when its coordinates lie inside the programmed rectangle and its valid strobe is high.

Four statistics are available. The first is a gradient energy: the sum of the differences between neighbouring pixels, with each difference reduced by a noise floor and clamped at zero. The others are a plain sum of pixel values, the smallest and largest values, and a count of samples on one chosen side of a level. Each can run on one channel or on all three. A host either asks for a single frame, and sees the request bit drop once the result is ready, or leaves the engine running so that it refreshes the result every frame behind a poll flag and a freeze control.

Top module: `ws_video_stats`

## Requirements
- R1: After reset, `result` is 0, `start_busy` is 0 and `poll` is 0.
- R2: The column coordinate is 0 in the cycle of a horizontal reference edge and then rises by 1 per clock, saturating at 4095. The row coordinate is 0 in the cycle of a vertical reference edge and rises by 1 at each later horizontal reference edge, saturating at 4095. A pixel is measured when `pix_vld` is high and both coordinates lie within the inclusive bounds `win_x_lo..win_x_hi` and `win_y_lo..win_y_hi`. A pixel presented in the cycle of a vertical reference edge is never measured.
- R3: With `x_ref_fall` (or `y_ref_fall`) at 1 the horizontal (or vertical) reference edge is the falling edge of `hsync` (or `vsync`); at 0 it is the rising edge.
- R4: With `alg_sel`=0, the result is the sum over measured pixels, and over the selected channels, of max(|p − q| − `level`, 0), where q is the previous measured pixel of the same line; the first measured pixel after a horizontal reference edge adds nothing.
- R5: With `alg_sel`=1, the result is the sum of the selected channel values of all measured pixels.
- R6: With `alg_sel`=2, `result[7:0]` is the smallest and `result[15:8]` the largest selected channel value in the frame, the upper bits zero; a frame with no measured pixel gives min 0xFF and max 0x00.
- R7: With `alg_sel`=3, the result counts selected channel samples strictly greater than `level`, or strictly less than `level` when `pcd_below` is 1.
- R8: `chan_sel` 0, 1 and 2 select red, green and blue; 3 selects all three, each channel contributing its own term or sample.
- R9: Algorithm, channel, level, direction and window are taken at the vertical reference edge that opens a measurement; changing them during a frame has no effect on that frame's result.
- R10: A one-cycle `start` while `free_run` is 0 raises `start_busy` from the next cycle; the measurement covers the frame from the next vertical reference edge to the following one, and one cycle after that closing edge `result` holds the value and `start_busy` is 0. Without `start`, frames leave `result` unchanged.
- R11: While `free_run` stays 1, every frame closing at a vertical reference edge updates `result` and sets `poll` one cycle after that edge; `poll` is cleared the cycle after `free_run` is seen at 0.
- R12: While `freeze` is 1 in free-running mode, closing frames leave `result` unchanged.
- R13: The accumulators never wrap for windows up to 4096×4096 pixels at all-channel selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_vld | input | 1 | Pixel strobe |
| pix_r | input | DATA_W | Red sample |
| pix_g | input | DATA_W | Green sample |
| pix_b | input | DATA_W | Blue sample |
| hsync | input | 1 | Horizontal sync, positive polarity |
| vsync | input | 1 | Vertical sync, positive polarity |
| win_x_lo | input | COORD_W | Left column of the window |
| win_y_lo | input | COORD_W | Top row of the window |
| win_x_hi | input | COORD_W | Right column of the window |
| win_y_hi | input | COORD_W | Bottom row of the window |
| x_ref_fall | input | 1 | Horizontal reference is the falling edge |
| y_ref_fall | input | 1 | Vertical reference is the falling edge |
| alg_sel | input | 2 | Statistic: 0 gradient, 1 sum, 2 min/max, 3 count |
| chan_sel | input | 2 | Channel: 0 red, 1 green, 2 blue, 3 all |
| level | input | DATA_W | Noise floor or count threshold |
| free_run | input | 1 | Refresh every frame |
| start | input | 1 | Single-frame request pulse |
| freeze | input | 1 | Hold result in free-running mode |
| pcd_below | input | 1 | Count samples below instead of above |
| result | output | ACC_W | Measured statistic |
| start_busy | output | 1 | Single-frame request pending |
| poll | output | 1 | Free-running result valid |

## Verification
The bench aims at the frame seams: a valid pixel driven in the cycle of the vertical edge, a configuration swapped in mid-frame, and reference edges switched to falling. A design that measured the edge-cycle pixel or applied settings at once would report a sum or count differing from the model. Gradient terms at the start of each line catch a design that carries the previous pixel across lines, and random levels above the deltas catch a missing clamp, which would inflate the sum by wrapped terms. Freeze and the drop of free-running mode are checked for a result that keeps moving or a poll flag that stays up.

// File: rtl/ws_pkg.sv
package ws_pkg;
  typedef enum logic [1:0] {
    ALG_GRAD   = 2'd0,
    ALG_SUM    = 2'd1,
    ALG_MINMAX = 2'd2,
    ALG_COUNT  = 2'd3
  } ws_alg_e;

  typedef enum logic [1:0] {
    CH_RED   = 2'd0,
    CH_GREEN = 2'd1,
    CH_BLUE  = 2'd2,
    CH_ALL   = 2'd3
  } ws_chan_e;
endpackage

// File: rtl/ws_frame_timer.sv
module ws_frame_timer #(
  parameter int COORD_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hsync,
  input  logic               vsync,
  input  logic               x_fall,
  input  logic               y_fall,
  input  logic               pix_vld,
  input  logic [COORD_W-1:0] x_lo,
  input  logic [COORD_W-1:0] x_hi,
  input  logic [COORD_W-1:0] y_lo,
  input  logic [COORD_W-1:0] y_hi,
  output logic               hedge,
  output logic               vedge,
  output logic               in_win
);
  localparam logic [COORD_W-1:0] CMAX = '1;

  logic               hs_q, vs_q;
  logic [COORD_W-1:0] x_q, y_q, x_cur, y_cur;

  assign hedge = x_fall ? (hs_q & ~hsync) : (hsync & ~hs_q);
  assign vedge = y_fall ? (vs_q & ~vsync) : (vsync & ~vs_q);

  always_comb begin
    if (hedge)             x_cur = '0;
    else if (x_q == CMAX)  x_cur = CMAX;
    else                   x_cur = x_q + 1'b1;

    if (vedge)             y_cur = '0;
    else if (!hedge)       y_cur = y_q;
    else if (y_q == CMAX)  y_cur = CMAX;
    else                   y_cur = y_q + 1'b1;
  end

  assign in_win = pix_vld & ~vedge &
                  (x_cur >= x_lo) & (x_cur <= x_hi) &
                  (y_cur >= y_lo) & (y_cur <= y_hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q <= 1'b0;
      vs_q <= 1'b0;
      x_q  <= '0;
      y_q  <= '0;
    end else begin
      hs_q <= hsync;
      vs_q <= vsync;
      x_q  <= x_cur;
      y_q  <= y_cur;
    end
  end

  // R2: the row coordinate only moves at a horizontal or vertical edge
  assert_row_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!hedge && !vedge) |=> $stable(y_q));
endmodule

// File: rtl/ws_pixel_stats.sv
module ws_pixel_stats
  import ws_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ACC_W  = 34
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   frame_rst,
  input  logic                   line_rst,
  input  logic                   sample,
  input  logic [2:0][DATA_W-1:0] pix,
  input  ws_chan_e               chan,
  input  logic [DATA_W-1:0]      level,
  input  logic                   below,
  output logic [ACC_W-1:0]       grad_acc,
  output logic [ACC_W-1:0]       sum_acc,
  output logic [ACC_W-1:0]       cnt_acc,
  output logic [DATA_W-1:0]      min_q,
  output logic [DATA_W-1:0]      max_q
);
  localparam int TERM_W = DATA_W + 2;

  logic [2:0]              sel, hit;
  logic [2:0][DATA_W-1:0]  gterm, sterm, prev_q, prev_n;
  logic                    pv_q, pv_n, pv_eff;
  logic [TERM_W-1:0]       gsum, ssum;
  logic [1:0]              hcnt;
  logic [DATA_W-1:0]       lo, hi, min_n, max_n;
  logic [ACC_W-1:0]        grad_n, sum_n, cnt_n;

  assign pv_eff = pv_q & ~line_rst;

  for (genvar c = 0; c < 3; c++) begin : g_chan
    logic [DATA_W-1:0] dlt;
    assign sel[c]   = (chan == CH_ALL) || (chan == ws_chan_e'(2'(c)));
    assign dlt      = (pix[c] >= prev_q[c]) ? pix[c] - prev_q[c] : prev_q[c] - pix[c];
    assign gterm[c] = (sel[c] && pv_eff && (dlt > level)) ? dlt - level : '0;
    assign sterm[c] = sel[c] ? pix[c] : '0;
    assign hit[c]   = sel[c] && (below ? (pix[c] < level) : (pix[c] > level));
  end

  always_comb begin
    gsum = TERM_W'(gterm[0]) + TERM_W'(gterm[1]) + TERM_W'(gterm[2]);
    ssum = TERM_W'(sterm[0]) + TERM_W'(sterm[1]) + TERM_W'(sterm[2]);
    hcnt = 2'(hit[0]) + 2'(hit[1]) + 2'(hit[2]);
    lo = min_q;
    hi = max_q;
    for (int c = 0; c < 3; c++) begin
      if (sel[c] && (pix[c] < lo)) lo = pix[c];
      if (sel[c] && (pix[c] > hi)) hi = pix[c];
    end

    grad_n = grad_acc;
    sum_n  = sum_acc;
    cnt_n  = cnt_acc;
    min_n  = min_q;
    max_n  = max_q;
    prev_n = prev_q;
    pv_n   = pv_q;
    if (frame_rst) begin
      grad_n = '0;
      sum_n  = '0;
      cnt_n  = '0;
      min_n  = '1;
      max_n  = '0;
      pv_n   = 1'b0;
    end else if (sample) begin
      grad_n = grad_acc + ACC_W'(gsum);
      sum_n  = sum_acc + ACC_W'(ssum);
      cnt_n  = cnt_acc + ACC_W'(hcnt);
      min_n  = lo;
      max_n  = hi;
      prev_n = pix;
      pv_n   = 1'b1;
    end else if (line_rst) begin
      pv_n   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grad_acc <= '0;
      sum_acc  <= '0;
      cnt_acc  <= '0;
      min_q    <= '1;
      max_q    <= '0;
      prev_q   <= '0;
      pv_q     <= 1'b0;
    end else begin
      grad_acc <= grad_n;
      sum_acc  <= sum_n;
      cnt_acc  <= cnt_n;
      min_q    <= min_n;
      max_q    <= max_n;
      prev_q   <= prev_n;
      pv_q     <= pv_n;
    end
  end

  // R13: within a frame no accumulator ever goes backwards (no wrap)
  assert_no_overflow_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_rst |=> (grad_acc >= $past(grad_acc)) && (sum_acc >= $past(sum_acc)) &&
                   (cnt_acc >= $past(cnt_acc)));

  // R6: running minimum never rises and running maximum never falls mid-frame
  assert_minmax_monotone_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_rst |=> (min_q <= $past(min_q)) && (max_q >= $past(max_q)));
endmodule

// File: rtl/ws_video_stats.sv
module ws_video_stats
  import ws_pkg::*;
#(
  parameter int  DATA_W  = 8,
  parameter int  COORD_W = 12,
  localparam int ACC_W   = 2 * COORD_W + DATA_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pix_vld,
  input  logic [DATA_W-1:0]  pix_r,
  input  logic [DATA_W-1:0]  pix_g,
  input  logic [DATA_W-1:0]  pix_b,
  input  logic               hsync,
  input  logic               vsync,
  input  logic [COORD_W-1:0] win_x_lo,
  input  logic [COORD_W-1:0] win_y_lo,
  input  logic [COORD_W-1:0] win_x_hi,
  input  logic [COORD_W-1:0] win_y_hi,
  input  logic               x_ref_fall,
  input  logic               y_ref_fall,
  input  logic [1:0]         alg_sel,
  input  logic [1:0]         chan_sel,
  input  logic [DATA_W-1:0]  level,
  input  logic               free_run,
  input  logic               start,
  input  logic               freeze,
  input  logic               pcd_below,
  output logic [ACC_W-1:0]   result,
  output logic               start_busy,
  output logic               poll
);
  // reset: asynchronous assertion, synchronous release
  logic [1:0] rs_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  // configuration shadow, loaded at each vertical reference edge
  ws_alg_e            a_alg;
  ws_chan_e           a_chan;
  logic [DATA_W-1:0]  a_level;
  logic               a_below, a_free;
  logic [COORD_W-1:0] a_x0, a_x1, a_y0, a_y1;

  logic hedge, vedge, in_win;
  logic [ACC_W-1:0]  grad_acc, sum_acc, cnt_acc, value;
  logic [DATA_W-1:0] min_q, max_q;

  ws_frame_timer #(.COORD_W(COORD_W)) u_timer (
    .clk(clk), .rst_n(rst_i), .hsync(hsync), .vsync(vsync),
    .x_fall(x_ref_fall), .y_fall(y_ref_fall), .pix_vld(pix_vld),
    .x_lo(a_x0), .x_hi(a_x1), .y_lo(a_y0), .y_hi(a_y1),
    .hedge(hedge), .vedge(vedge), .in_win(in_win)
  );

  ws_pixel_stats #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_stats (
    .clk(clk), .rst_n(rst_i), .frame_rst(vedge), .line_rst(hedge),
    .sample(in_win), .pix({pix_b, pix_g, pix_r}), .chan(a_chan),
    .level(a_level), .below(a_below),
    .grad_acc(grad_acc), .sum_acc(sum_acc), .cnt_acc(cnt_acc),
    .min_q(min_q), .max_q(max_q)
  );

  always_comb begin
    unique case (a_alg)
      ALG_GRAD:   value = grad_acc;
      ALG_SUM:    value = sum_acc;
      ALG_MINMAX: value = ACC_W'({max_q, min_q});
      default:    value = cnt_acc;
    endcase
  end

  // measurement control
  logic running_q, running_n, armed_q, armed_n, armed_eff;
  logic poll_n, res_en;
  logic [ACC_W-1:0] result_n;

  always_comb begin
    armed_eff = armed_q | start;
    running_n = running_q;
    armed_n   = armed_eff;
    res_en    = 1'b0;
    poll_n    = poll;
    if (vedge) begin
      res_en    = running_q & (a_free ? (free_run & ~freeze) : 1'b1);
      running_n = free_run | armed_eff;
      armed_n   = free_run & armed_eff;
    end
    if (!free_run)                   poll_n = 1'b0;
    else if (res_en && a_free)       poll_n = 1'b1;
    result_n = res_en ? value : result;
  end

  assign start_busy = armed_q | (running_q & ~a_free);

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      running_q <= 1'b0;
      armed_q   <= 1'b0;
      poll      <= 1'b0;
      result    <= '0;
      a_alg     <= ALG_GRAD;
      a_chan    <= CH_RED;
      a_level   <= '0;
      a_below   <= 1'b0;
      a_free    <= 1'b0;
      a_x0      <= '0;
      a_x1      <= '0;
      a_y0      <= '0;
      a_y1      <= '0;
    end else begin
      running_q <= running_n;
      armed_q   <= armed_n;
      poll      <= poll_n;
      result    <= result_n;
      if (vedge) begin
        a_alg   <= ws_alg_e'(alg_sel);
        a_chan  <= ws_chan_e'(chan_sel);
        a_level <= level;
        a_below <= pcd_below;
        a_free  <= free_run;
        a_x0    <= win_x_lo;
        a_x1    <= win_x_hi;
        a_y0    <= win_y_lo;
        a_y1    <= win_y_hi;
      end
    end
  end

  // R10: the single-frame request only drops right after a vertical edge
  assert_busy_drop_R10: assert property (@(posedge clk) disable iff (!rst_i)
    $fell(start_busy) |-> $past(vedge));

  // R12: the reported value only moves right after a vertical edge
  assert_result_hold_R12: assert property (@(posedge clk) disable iff (!rst_i)
    !vedge |=> $stable(result));

  // R11: poll only falls once free-running mode has been left
  assert_poll_clear_R11: assert property (@(posedge clk) disable iff (!rst_i)
    $fell(poll) |-> !$past(free_run));
endmodule

// File: tb/tb_ws_video_stats.sv
module tb_ws_video_stats;
  localparam int ACC_W = 34;

  logic clk, rst_n;
  logic pix_vld, hsync, vsync;
  logic [7:0] pix_r, pix_g, pix_b;
  logic [11:0] win_x_lo, win_y_lo, win_x_hi, win_y_hi;
  logic x_ref_fall, y_ref_fall, free_run, start, freeze, pcd_below;
  logic [1:0] alg_sel, chan_sel;
  logic [7:0] level;
  logic [ACC_W-1:0] result;
  logic start_busy, poll;

  ws_video_stats dut (
    .clk(clk), .rst_n(rst_n), .pix_vld(pix_vld), .pix_r(pix_r), .pix_g(pix_g),
    .pix_b(pix_b), .hsync(hsync), .vsync(vsync), .win_x_lo(win_x_lo),
    .win_y_lo(win_y_lo), .win_x_hi(win_x_hi), .win_y_hi(win_y_hi),
    .x_ref_fall(x_ref_fall), .y_ref_fall(y_ref_fall), .alg_sel(alg_sel),
    .chan_sel(chan_sel), .level(level), .free_run(free_run), .start(start),
    .freeze(freeze), .pcd_below(pcd_below), .result(result),
    .start_busy(start_busy), .poll(poll)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0, n_cyc = 0;
  bit done = 0;

  // reference model state
  logic m_hs = 0, m_vs = 0;
  int m_x = 0, m_y = 0;
  logic [ACC_W-1:0] m_grad = 0, m_sum = 0, m_cnt = 0, m_final = 0;
  logic [7:0] m_min = 8'hFF, m_max = 0, m_thr = 0;
  logic [7:0] m_prev [3];
  bit m_pv = 0, m_below = 0;
  int m_alg = 0, m_chan = 0, m_x0 = 0, m_x1 = 0, m_y0 = 0, m_y1 = 0;

  function automatic logic [ACC_W-1:0] model_value();
    case (m_alg)
      0: return m_grad;
      1: return m_sum;
      2: return ACC_W'({m_max, m_min});
      default: return m_cnt;
    endcase
  endfunction

  function automatic string rtag(int a);
    case (a)
      0: return "R4 gradient";
      1: return "R5 sum";
      2: return "R6 minmax";
      default: return "R7 count";
    endcase
  endfunction

  task automatic chk(input logic [ACC_W-1:0] act, input logic [ACC_W-1:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic hs, input logic vs, input logic vld,
                     input logic [7:0] r, input logic [7:0] g, input logic [7:0] b);
    logic he, ve;
    logic [7:0] px [3];
    bit inw;
    int d;
    hsync = hs; vsync = vs; pix_vld = vld; pix_r = r; pix_g = g; pix_b = b;
    px[0] = r; px[1] = g; px[2] = b;
    he = x_ref_fall ? (m_hs & !hs) : (hs & !m_hs);
    ve = y_ref_fall ? (m_vs & !vs) : (vs & !m_vs);
    if (ve) begin
      m_final = model_value();
      m_alg = int'(alg_sel); m_chan = int'(chan_sel); m_thr = level; m_below = pcd_below;
      m_x0 = int'(win_x_lo); m_x1 = int'(win_x_hi); m_y0 = int'(win_y_lo); m_y1 = int'(win_y_hi);
      m_grad = 0; m_sum = 0; m_cnt = 0; m_min = 8'hFF; m_max = 0; m_pv = 0;
    end
    m_x = he ? 0 : (m_x < 4095 ? m_x + 1 : 4095);
    if (ve) m_y = 0;
    else if (he) m_y = (m_y < 4095) ? m_y + 1 : 4095;
    if (he) m_pv = 0;
    inw = vld && !ve && m_x >= m_x0 && m_x <= m_x1 && m_y >= m_y0 && m_y <= m_y1;
    if (inw) begin
      for (int c = 0; c < 3; c++) begin
        if (m_chan == 3 || m_chan == c) begin
          d = int'(px[c]) - int'(m_prev[c]);
          if (d < 0) d = -d;
          if (m_pv && d > int'(m_thr)) m_grad += ACC_W'(d - int'(m_thr));
          m_sum += ACC_W'(px[c]);
          if (px[c] < m_min) m_min = px[c];
          if (px[c] > m_max) m_max = px[c];
          if (m_below ? (px[c] < m_thr) : (px[c] > m_thr)) m_cnt += 1;
        end
        m_prev[c] = px[c];
      end
      m_pv = 1;
    end
    m_hs = hs; m_vs = vs;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic vpulse(input bit vld_first);
    cyc(0, 1, vld_first, 8'($urandom), 8'($urandom), 8'($urandom));
    cyc(0, 1, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0);
  endtask

  task automatic lines(input int nl, input int np);
    for (int l = 0; l < nl; l++) begin
      cyc(1, 0, 0, 0, 0, 0);
      cyc(1, 0, 0, 0, 0, 0);
      for (int p = 0; p < np; p++)
        cyc(0, 0, 1, 8'($urandom), 8'($urandom), 8'($urandom));
      cyc(0, 0, 0, 0, 0, 0);
    end
  endtask

  // watchdog
  always @(posedge clk) begin
    n_cyc++;
    if (n_cyc > 150000 && !done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", n_cyc);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  logic [ACC_W-1:0] keep;

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; pix_vld = 0; hsync = 0; vsync = 0; pix_r = 0; pix_g = 0; pix_b = 0;
    win_x_lo = 0; win_y_lo = 0; win_x_hi = 12'hFFF; win_y_hi = 12'hFFF;
    x_ref_fall = 0; y_ref_fall = 0; alg_sel = 1; chan_sel = 3; level = 0;
    free_run = 0; start = 0; freeze = 0; pcd_below = 0;
    for (int i = 0; i < 3; i++) @(negedge clk);
    chk(result, 0, "R1 result");
    chk(ACC_W'(start_busy), 0, "R1 busy");
    chk(ACC_W'(poll), 0, "R1 poll");
    rst_n = 1;
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, 0);

    // full window, valid pixel in the vertical edge cycle must be ignored
    start = 1;
    vpulse(1);
    chk(ACC_W'(start_busy), 1, "R10 busy while measuring");
    lines(3, 6);
    vpulse(1);
    chk(result, m_final, "R2 full window sum, edge-cycle pixel excluded (R8 all)");
    chk(ACC_W'(start_busy), 0, "R10 busy cleared");

    // random configurations over every statistic and channel choice
    for (int i = 0; i < 16; i++) begin
      alg_sel = 2'(i % 4); chan_sel = 2'(i / 4);
      level = 8'($urandom_range(0, 200)); pcd_below = 1'($urandom);
      win_x_lo = 12'($urandom_range(0, 4)); win_x_hi = win_x_lo + 12'($urandom_range(0, 7));
      win_y_lo = 12'($urandom_range(1, 2)); win_y_hi = win_y_lo + 12'($urandom_range(0, 2));
      start = 1;
      vpulse(0);
      lines(4, 9);
      vpulse(0);
      chk(result, m_final, {rtag(i % 4), " R8 chan=", $sformatf("%0d", i / 4)});
    end

    // directed: a level above all deltas clamps every gradient term
    alg_sel = 0; chan_sel = 3; level = 8'd255; win_x_lo = 0; win_x_hi = 12'hFFF;
    win_y_lo = 0; win_y_hi = 12'hFFF;
    start = 1; vpulse(0); lines(2, 8); vpulse(0);
    chk(result, 0, "R4 clamp at level 255");

    // directed: empty window gives min 0xFF and max 0x00
    alg_sel = 2; win_x_lo = 12'd100; win_x_hi = 12'd110;
    start = 1; vpulse(0); lines(2, 8); vpulse(0);
    chk(result, ACC_W'(16'h00FF), "R6 empty window");

    // configuration swapped during a measurement
    alg_sel = 1; chan_sel = 1; level = 8'd40; win_x_lo = 2; win_x_hi = 8;
    win_y_lo = 1; win_y_hi = 3;
    start = 1; vpulse(0);
    alg_sel = 3; chan_sel = 0; win_x_lo = 5; win_x_hi = 5; level = 8'd0;
    lines(3, 8);
    vpulse(0);
    chk(result, m_final, "R9 settings held for the running frame");

    // falling reference edges
    x_ref_fall = 1; y_ref_fall = 1; alg_sel = 1; chan_sel = 3;
    win_x_lo = 0; win_x_hi = 3; win_y_lo = 1; win_y_hi = 2;
    start = 1; vpulse(0); lines(3, 6); vpulse(0);
    chk(result, m_final, "R3 falling edges");
    cyc(0, 0, 0, 0, 0, 0);
    x_ref_fall = 0; y_ref_fall = 0;

    // free-running mode, then freeze, then leave
    alg_sel = 1; chan_sel = 2; win_x_lo = 2; win_x_hi = 10; win_y_lo = 1; win_y_hi = 4;
    free_run = 1;
    vpulse(0); lines(3, 8); vpulse(0);
    chk(result, m_final, "R11 free-run first frame");
    chk(ACC_W'(poll), 1, "R11 poll set");
    lines(3, 8); vpulse(0);
    chk(result, m_final, "R11 free-run second frame");
    keep = result;
    freeze = 1;
    lines(3, 8); vpulse(0);
    chk(result, keep, "R12 frozen result");
    chk(ACC_W'(poll), 1, "R12 poll kept");
    free_run = 0;
    cyc(0, 0, 0, 0, 0, 0);
    chk(ACC_W'(poll), 0, "R11 poll cleared");
    freeze = 0;

    // frames without a request leave the result alone
    keep = result;
    vpulse(0); lines(2, 8); vpulse(0);
    chk(result, keep, "R10 no update without start");
    chk(ACC_W'(start_busy), 0, "R10 idle busy");

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule